// File: doc/BRIEF.md
# Two-Wire Bus Master Frame Engine

This block is the protocol engine on the master side of one channel of a two-wire bus that carries both supply power and data. The host places command words into a four-entry circular queue. The engine takes the oldest pending command and transmits it as a frame. Each bit of the frame is duty-cycle coded: a one and a zero differ only in how long the line is held low before it returns high. After the data bits the engine appends a CRC. In the same frame it samples the slave's current-mode reply from the receiver comparator, one reply bit per transmitted bit. It checks the CRC of the reply and writes the reply back into the queue entry that held the command. The host then reads the reply and frees the entry.

Timing comes from a strobe, `tick`, that pulses three times per bit period. Two outputs, `drv_idle` and `drv_level`, control the analog driver. With `drv_idle`=1 and `drv_level`=1 the driver is in the idle (power) state. With `drv_idle`=0 the driver is signalling, and `drv_level` selects the high or the low level. The code `drv_idle`=1 with `drv_level`=0 means high impedance. This engine never drives that code.

The engine's controller has four states:
- `ST_IDLE` waits for a pending command (IDLE→GAP when one exists).
- `ST_GAP` counts the inter-frame delay in ticks (GAP→BIT when the count reaches its goal).
- `ST_BIT` steps through three tick phases per bit (BIT→DONE on the tick that ends the last bit).
- `ST_DONE` hands the reply to the queue for one cycle (DONE→IDLE).

Top module: `dbus_master_channel`

## Requirements
- R1: Outside a frame the outputs sit at `drv_idle`=1, `drv_level`=1. The high-impedance code (`drv_idle`=1, `drv_level`=0) is never produced.
- R2: A bit lasts three tick periods and begins with `drv_level` low. A one is low for one tick period and a zero for two; the bit then ends high. Outputs change only in the cycle after a `tick`.
- R3: A frame sends the low L bits of the command, MSB first, then C CRC bits, MSB first. L and C come from `cfg_len` and `cfg_crc`, which are latched at frame start.
- R4: L is clamped to the range 8..16. C is clamped to at most 8, and C=0 sends no CRC.
- R5: The CRC is computed over the L data bits, MSB first, with the polynomial x^8+x^4+x^3+x^2+1 and a zero seed. A C-bit CRC is the low C bits of this result.
- R6: `rx_in` is sampled on the tick that ends each bit slot, where `drv_level` falls to start the next bit or the frame ends. The first L samples form the reply, which appears in the low L bits of `rsp_data` with the upper bits zero.
- R7: After a frame, `rsp_ready`=1 for that entry. `rsp_valid` is 1 only if the last C samples equal the CRC of the reply data; with C=0 it is always 1. Pulsing `rsp_rd` while `rsp_ready`=1 frees the entry and clears both flags.
- R8: The queue holds four commands and sends them in write order. `q_full`=1 while four entries are occupied, counting both unsent commands and unread replies. A write while full is ignored.
- R9: Between consecutive frames the outputs stay idle for exactly 3*`cfg_dly`+1 tick periods.
- R10: With no pending command the outputs stay idle indefinitely.
- R11: After reset the outputs are idle, the queue is empty, `q_full`=0 and `rsp_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Strobe, three pulses per bit period |
| cfg_len | input | 5 | Data bit count L (clamped 8..16) |
| cfg_crc | input | 4 | CRC bit count C (clamped 0..8) |
| cfg_dly | input | 4 | Inter-frame delay in bit periods |
| cmd_wr | input | 1 | Write a command into the queue |
| cmd_data | input | 16 | Command word |
| q_full | output | 1 | All four queue entries occupied |
| rsp_rd | input | 1 | Read and free the oldest completed entry |
| rsp_ready | output | 1 | Oldest entry holds a completed reply |
| rsp_valid | output | 1 | Reply in the oldest entry passed its CRC |
| rsp_data | output | 16 | Reply data of the oldest entry |
| rx_in | input | 1 | Receiver comparator output |
| drv_idle | output | 1 | Driver control: 1 = not signalling |
| drv_level | output | 1 | Driver control: signal level |

## Verification
The hardest case to reach is the queue run back to back: four frames in flight while a fifth write arrives, with the idle gaps measured exactly between frames. The stimulus writes five commands on consecutive cycles before the first frame can start, then checks each frame's bits and the idle cycles before it. The bench's slave model decodes every bit from the width of its low phase. On each falling edge of `drv_level` it presents the reply bit, drawn from a table indexed by frame number, so that replies with good and with corrupted CRCs can be placed on specific queue entries.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;

    typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_BIT, ST_DONE} eng_state_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/dbus_cmd_queue.sv
module dbus_cmd_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         tx_avail,
    output logic [W-1:0] tx_data,
    input  logic         fin,
    input  logic [W-1:0] fin_data,
    input  logic         fin_good,
    input  logic         pop,
    output logic         rd_ready,
    output logic         rd_good,
    output logic [W-1:0] rd_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]     cmd_mem [DEPTH];
    logic [W-1:0]     rsp_mem [DEPTH];
    logic [DEPTH-1:0] pend, done, good;
    logic [PW-1:0]    wr_ptr, tx_ptr, rd_ptr;
    logic [CW-1:0]    occ;
    logic             push_ok, pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (occ == CW'(DEPTH));
    assign push_ok  = push && !full;
    assign pop_ok   = pop && done[rd_ptr];
    assign tx_avail = pend[tx_ptr];
    assign tx_data  = cmd_mem[tx_ptr];
    assign rd_ready = done[rd_ptr];
    assign rd_good  = good[rd_ptr];
    assign rd_data  = rsp_mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) cmd_mem[wr_ptr] <= push_data;
        if (fin)     rsp_mem[tx_ptr] <= fin_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= '0;
            done   <= '0;
            good   <= '0;
            wr_ptr <= '0;
            tx_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) begin
                pend[wr_ptr] <= 1'b1;
                wr_ptr       <= nxt(wr_ptr);
            end
            if (fin) begin
                pend[tx_ptr] <= 1'b0;
                done[tx_ptr] <= 1'b1;
                good[tx_ptr] <= fin_good;
                tx_ptr       <= nxt(tx_ptr);
            end
            if (pop_ok) begin
                done[rd_ptr] <= 1'b0;
                good[rd_ptr] <= 1'b0;
                rd_ptr       <= nxt(rd_ptr);
            end
            occ <= occ + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/dbus_frame_fsm.sv
module dbus_frame_fsm
    import dbus_pkg::*;
#(
    parameter int W     = 16,
    parameter int DLY_W = 4,
    parameter int LEN_W = 5,
    parameter int CL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CL_W-1:0]  cfg_crc,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             tx_avail,
    input  logic [W-1:0]     tx_data,
    input  logic             rx,
    output logic             drv_idle,
    output logic             drv_level,
    output logic             fin,
    output logic [W-1:0]     fin_data,
    output logic             fin_good
);
    localparam int MIN_LEN = 8;
    localparam int BI_W    = $clog2(W + CRC_W + 1);
    localparam int GC_W    = DLY_W + 2;

    eng_state_t       state;
    logic [1:0]       phase;
    logic [BI_W-1:0]  bidx, len_q, crcn_q, len_eff, crc_eff;
    logic [BI_W-1:0]  d_ix, c_pos, c_ix;
    logic [W-1:0]     cmd_q, rx_sh;
    logic [CRC_W-1:0] tx_crc, rx_crc;
    logic [GC_W-1:0]  gcnt, gap_goal;
    logic             bad_q, in_crc, cur_bit, exp_rx, last_bit;

    // Configuration clamping
    always_comb begin
        if (cfg_len < LEN_W'(MIN_LEN))  len_eff = BI_W'(MIN_LEN);
        else if (cfg_len > LEN_W'(W))   len_eff = BI_W'(W);
        else                            len_eff = BI_W'(cfg_len);
        if (cfg_crc > CL_W'(CRC_W))     crc_eff = BI_W'(CRC_W);
        else                            crc_eff = BI_W'(cfg_crc);
    end

    assign gap_goal = GC_W'(cfg_dly) * GC_W'(3);
    assign in_crc   = (bidx >= len_q);
    assign d_ix     = len_q - BI_W'(1) - bidx;
    assign c_pos    = bidx - len_q;
    assign c_ix     = crcn_q - BI_W'(1) - c_pos;
    assign last_bit = (bidx == len_q + crcn_q - BI_W'(1));

    // Bit selection: data bit or CRC bit, both MSB first
    always_comb begin
        logic dbit, cbit;
        dbit = 1'b0;
        cbit = 1'b0;
        for (int i = 0; i < W; i++)
            if (BI_W'(i) == d_ix) dbit = cmd_q[i];
        for (int i = 0; i < CRC_W; i++)
            if (BI_W'(i) == c_ix) cbit = rx_crc[i];
        cur_bit = dbit;
        for (int i = 0; i < CRC_W; i++)
            if (in_crc && BI_W'(i) == c_ix) cur_bit = tx_crc[i];
        exp_rx = cbit;
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= '0;
            bidx   <= '0;
            len_q  <= BI_W'(MIN_LEN);
            crcn_q <= '0;
            cmd_q  <= '0;
            rx_sh  <= '0;
            tx_crc <= '0;
            rx_crc <= '0;
            gcnt   <= '0;
            bad_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    gcnt <= '0;
                    if (tx_avail) state <= ST_GAP;
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gcnt == gap_goal) begin
                            state  <= ST_BIT;
                            cmd_q  <= tx_data;
                            len_q  <= len_eff;
                            crcn_q <= crc_eff;
                            phase  <= '0;
                            bidx   <= '0;
                            tx_crc <= '0;
                            rx_crc <= '0;
                            rx_sh  <= '0;
                            bad_q  <= 1'b0;
                        end else begin
                            gcnt <= gcnt + 1'b1;
                        end
                    end
                end
                ST_BIT: begin
                    if (tick) begin
                        if (phase != 2'd2) begin
                            phase <= phase + 1'b1;
                        end else begin
                            phase <= '0;
                            bidx  <= bidx + 1'b1;
                            if (!in_crc) begin
                                tx_crc <= crc_step(tx_crc, cur_bit);
                                rx_crc <= crc_step(rx_crc, rx);
                                rx_sh  <= {rx_sh[W-2:0], rx};
                            end else if (rx != exp_rx) begin
                                bad_q <= 1'b1;
                            end
                            if (last_bit) state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        drv_idle  = 1'b1;
        drv_level = 1'b1;
        fin       = 1'b0;
        unique case (state)
            ST_BIT: begin
                drv_idle  = 1'b0;
                drv_level = (phase == 2'd0) ? 1'b0 : (phase == 2'd1) ? cur_bit : 1'b1;
            end
            ST_DONE: fin = 1'b1;
            default: ;
        endcase
    end

    assign fin_data = rx_sh;
    assign fin_good = !bad_q;
endmodule

// File: rtl/dbus_master_channel.sv
module dbus_master_channel #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int DLY_W = 4,
    localparam int LEN_W = $clog2(W + 1),
    localparam int CL_W  = $clog2(dbus_pkg::CRC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CL_W-1:0]  cfg_crc,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             cmd_wr,
    input  logic [W-1:0]     cmd_data,
    output logic             q_full,
    input  logic             rsp_rd,
    output logic             rsp_ready,
    output logic             rsp_valid,
    output logic [W-1:0]     rsp_data,
    input  logic             rx_in,
    output logic             drv_idle,
    output logic             drv_level
);
    logic         q_has_cmd, eng_fin, eng_good;
    logic [W-1:0] q_cmd, eng_rsp;

    dbus_cmd_queue #(.DEPTH(DEPTH), .W(W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_wr), .push_data(cmd_data), .full(q_full),
        .tx_avail(q_has_cmd), .tx_data(q_cmd),
        .fin(eng_fin), .fin_data(eng_rsp), .fin_good(eng_good),
        .pop(rsp_rd), .rd_ready(rsp_ready), .rd_good(rsp_valid), .rd_data(rsp_data)
    );

    dbus_frame_fsm #(.W(W), .DLY_W(DLY_W), .LEN_W(LEN_W), .CL_W(CL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_len(cfg_len), .cfg_crc(cfg_crc), .cfg_dly(cfg_dly),
        .tx_avail(q_has_cmd), .tx_data(q_cmd), .rx(rx_in),
        .drv_idle(drv_idle), .drv_level(drv_level),
        .fin(eng_fin), .fin_data(eng_rsp), .fin_good(eng_good)
    );
endmodule

// File: rtl/dbus_master_checker.sv
module dbus_master_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic drv_idle,
    input logic drv_level,
    input logic q_full,
    input logic cmd_wr,
    input logic rsp_rd,
    input logic q_has_cmd
);
    AST_NO_HIZ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_idle |-> drv_level);  // R1
    AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(drv_level) && $stable(drv_idle)));  // R2
    AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_idle) |-> !drv_level);  // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && cmd_wr && !rsp_rd) |=> q_full);  // R8
    AST_NO_FRAME_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_has_cmd && drv_idle) |=> drv_idle);  // R10
endmodule

bind dbus_master_channel dbus_master_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drv_idle(drv_idle), .drv_level(drv_level),
    .q_full(q_full), .cmd_wr(cmd_wr), .rsp_rd(rsp_rd), .q_has_cmd(q_has_cmd)
);

// File: tb/test_dbus_master_channel.sv
module test_dbus_master_channel;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [4:0]  cfg_len = 5'd8;
    logic [3:0]  cfg_crc = 4'd8, cfg_dly = 4'd2;
    logic        cmd_wr = 1'b0, rsp_rd = 1'b0, rx_in = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        q_full, rsp_ready, rsp_valid, drv_idle, drv_level;
    logic [15:0] rsp_data;

    int checks = 0, errors = 0;
    int frames = 0, cap_n = 0, fn = 0, lowcnt = 0, idle_run = 0, last_gap = 0;
    int odd_low = 0, hiz_seen = 0, tc = 0;
    logic [31:0] fbits = '0, cap_bits = '0;
    logic [31:0] resp_tab [4];
    int          resp_n_tab [4];
    logic        prev_idle = 1'b1, prev_lvl = 1'b1;

    dbus_master_channel i_dbus_master_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len), .cfg_crc(cfg_crc),
        .cfg_dly(cfg_dly), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .q_full(q_full),
        .rsp_rd(rsp_rd), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rx_in(rx_in), .drv_idle(drv_idle), .drv_level(drv_level)
    );

    always #5 clk = ~clk;

    // tick: one cycle in four
    always @(negedge clk) begin
        tc   = (tc + 1) % 4;
        tick = (tc == 0);
    end

    // bus monitor and slave model
    always @(negedge clk) begin
        if (drv_idle && !drv_level) hiz_seen++;
        if (!drv_idle) begin
            if (prev_idle) begin
                last_gap = idle_run;
                fn       = 0;
                fbits    = '0;
            end
            if (prev_lvl && !drv_level) begin
                rx_in  = (fn < resp_n_tab[frames & 3]) ?
                         resp_tab[frames & 3][resp_n_tab[frames & 3] - 1 - fn] : 1'b0;
                lowcnt = 0;
            end
            if (!drv_level) lowcnt++;
            if (!prev_lvl && drv_level) begin
                if (lowcnt != 4 && lowcnt != 8) odd_low++;
                fbits = {fbits[30:0], (lowcnt < 6)};
                fn++;
            end
        end else begin
            if (!prev_idle) begin
                cap_bits = fbits;
                cap_n    = fn;
                frames++;
                idle_run = 0;
            end
            idle_run++;
        end
        prev_idle = drv_idle;
        prev_lvl  = drv_level;
    end

    function automatic logic [7:0] crc8(input logic [15:0] d, input int n);
        logic [7:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = c[7] ^ d[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [31:0] frame_of(input logic [15:0] d, input int l, input int c);
        logic [31:0] dm = {16'b0, d} & ((32'd1 << l) - 1);
        logic [31:0] cm = {24'b0, crc8(dm[15:0], l)} & ((32'd1 << c) - 1);
        return (dm << c) | cm;
    endfunction

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, what, act, exp);
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rsp_rd = 1'b1;
        @(negedge clk); rsp_rd = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        int n = 0;
        while (frames < target && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!rsp_ready && n < 100) begin @(negedge clk); n++; end
    endtask

    // one command through the full round trip
    task automatic t_single(input string tag, input int cl, input int cc, input int l, input int c,
                            input logic [15:0] cmd, input logic [15:0] rdat, input logic corrupt);
        logic [31:0] rv = frame_of(rdat, l, c) ^ {31'b0, corrupt};
        logic [31:0] rmask = (32'd1 << l) - 1;
        int f0 = frames;
        cfg_len = 5'(cl); cfg_crc = 4'(cc);
        resp_tab[f0 & 3] = rv; resp_n_tab[f0 & 3] = l + c;
        push(cmd);
        wait_frames(f0 + 1);
        chk_eq({tag, " R3 R4 frame length"}, cap_n, l + c);
        chk_eq({tag, " R3 R5 frame bits"}, cap_bits, frame_of(cmd, l, c));
        wait_ready();
        chk_eq({tag, " R7 rsp_ready"}, rsp_ready, 1);
        chk_eq({tag, " R7 rsp_valid"}, rsp_valid, !corrupt);
        chk_eq({tag, " R6 rsp_data"}, rsp_data, {16'b0, rdat} & rmask);
        pop();
        chk_eq({tag, " R7 cleared after read"}, {rsp_ready, rsp_valid}, 0);
    endtask

    task automatic t_reset();
        chk_eq("R11 R1 idle outputs", {drv_idle, drv_level}, 2'b11);
        chk_eq("R11 q_full", q_full, 0);
        chk_eq("R11 rsp_ready", rsp_ready, 0);
    endtask

    task automatic t_queue();
        logic [15:0] cmds [5];
        int f0 = frames;
        cfg_len = 5'd8; cfg_crc = 4'd4; cfg_dly = 4'd2;
        for (int i = 0; i < 5; i++) cmds[i] = 16'h0011 * 16'(i + 3);
        for (int i = 0; i < 4; i++) begin
            resp_tab[(f0 + i) & 3]   = frame_of(16'(8'h90 + i), 8, 4);
            resp_n_tab[(f0 + i) & 3] = 12;
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); cmd_wr = 1'b1; cmd_data = cmds[i];
        end
        @(negedge clk); cmd_wr = 1'b0;
        chk_eq("R8 q_full after four writes", q_full, 1);
        for (int i = 0; i < 4; i++) begin
            wait_frames(f0 + i + 1);
            chk_eq("R8 order of frames", cap_bits, frame_of(cmds[i], 8, 4));
            if (i > 0) chk_eq("R9 idle gap cycles", last_gap, 28);
        end
        repeat (600) @(negedge clk);
        chk_eq("R8 fifth write ignored", frames, f0 + 4);
        for (int i = 0; i < 4; i++) begin
            wait_ready();
            chk_eq("R8 R7 reply order", {rsp_ready, rsp_valid, rsp_data}, {2'b11, 16'(8'h90 + i)});
            pop();
        end
        chk_eq("R8 q_full after reads", q_full, 0);
    endtask

    task automatic t_empty();
        int busy = 0;
        int f0 = frames;
        repeat (800) begin @(negedge clk); if (!drv_idle) busy++; end
        chk_eq("R10 no signalling when empty", busy, 0);
        chk_eq("R10 no frames when empty", frames, f0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin resp_tab[i] = '0; resp_n_tab[i] = 0; end
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_single("8+8 good", 8, 8, 8, 8, 16'h00A5, 16'h003C, 1'b0);
        t_single("16+0", 16, 0, 16, 0, 16'hBEEF, 16'h1234, 1'b0);
        t_single("12+4 bad crc", 12, 4, 12, 4, 16'h0ABC, 16'h0777, 1'b1);
        t_single("clamp", 3, 12, 8, 8, 16'hABCD, 16'h00E1, 1'b0);
        t_single("10+3 good", 10, 3, 10, 3, 16'h02F0, 16'h0155, 1'b0);
        t_queue();
        t_empty();
        chk_eq("R2 low phase widths", odd_low, 0);
        chk_eq("R1 no high-impedance code", hiz_seen, 0);
        finish_run();
    end
endmodule